// File: doc/BRIEF.md
# Speculative Load/Store Address Resolution Buffer

This block sits between several ordered speculative tasks and a backing data memory. A task may issue a load as soon as the load's address is known, without waiting for older tasks to resolve their stores. Each of the eight fully associative entries holds one address tag. For each of the four task stages an entry also holds a "has loaded" bit, a "has stored" bit and the stored value. A load returns the value written by the nearest task at or before its own stage, or the memory value when no such task has stored to that address. A store is held in the buffer. If a younger task has already read the same address too early, the store flags that task as violated.

Task IDs run from 0 (oldest) to 3 (youngest). Committing a task drains its buffered stores into memory one per cycle and then pulses a done flag. Squashing a task drops all of its bits. An entry with no bit left is free again. Control sits in a two-state machine. In `ST_IDLE` the block accepts a squash, a commit or a request, in that order of priority. A commit moves it to `ST_DRAIN` (transition IDLE→DRAIN). In `ST_DRAIN` it writes one store per cycle. When no store of the committing task is left, it clears that task's load bits, raises `commit_done` and returns (transition DRAIN→IDLE).

Top module: `spec_arb`

## Requirements
- R1: A load that finds no older-or-same-task store for its address returns the value read from memory at `mem_rd_addr` in the cycle it is accepted. `rsp_valid` and `rsp_data` are presented in the cycle after acceptance.
- R2: A load from task t returns the data of the highest-numbered task m ≤ t whose store bit is set for that address.
- R3: Stores are never written to memory while speculative. `mem_wr_en` is high only while a commit is draining.
- R4: An accepted store from task s scans tasks s+1 upward. The first task with its load bit set is reported on `viol_task` with `viol_valid` in the next cycle. The scan stops without a report at the first task that has its store bit set.
- R5: A commit of task t writes each of t's buffered stores to memory, one per cycle. It then raises `commit_done` for one cycle with no write. `req_ready` stays low until the commit is finished.
- R6: A squash of task t clears t's load and store bits in every entry. Entries left with no bits become free for new addresses.
- R7: When all 8 entries are in use, a request to an address not present holds `req_ready` low. A request to a present address is still accepted.
- R8: Priority in `ST_IDLE` is squash, then commit, then request. A cycle with `squash_valid` accepts neither the commit nor the request. After reset the buffer is empty, `req_ready` is high, and no response, violation, write or done is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load or store request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_task | input | 2 | Task stage of the request (0 oldest) |
| req_addr | input | 8 | Request address |
| req_wdata | input | 16 | Store data |
| req_ready | output | 1 | Request accepted this cycle when valid |
| rsp_valid | output | 1 | Load response valid |
| rsp_data | output | 16 | Load response data |
| viol_valid | output | 1 | A younger task read too early |
| viol_task | output | 2 | Task that must be squashed |
| commit_valid | input | 1 | Commit request |
| commit_task | input | 2 | Task to commit |
| squash_valid | input | 1 | Squash request |
| squash_task | input | 2 | Task to squash |
| commit_done | output | 1 | Commit finished (one-cycle pulse) |
| mem_rd_addr | output | 8 | Memory read address (follows req_addr) |
| mem_rd_data | input | 16 | Memory read data, combinational |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 8 | Memory write address |
| mem_wr_data | output | 16 | Memory write data |

## Verification
The load response and the violation flag are each due one clock after the request is accepted. The bench drives requests on the falling edge and reads `rsp_*`/`viol_*` on the following falling edge. For a commit of a task with k buffered stores, the bench counts write strobes on each falling edge from the accepting edge onward. It expects exactly k of them before `commit_done`, which falls in the (k+1)-th cycle. `req_ready` depends on the inputs of the same cycle, so it is checked 1 ns after the inputs are driven. On every falling edge the bench also checks that no memory write appears outside a commit.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } arb_state_e;
endpackage

// File: rtl/arb_pick.sv
// Lowest-index set bit of a vector.
module arb_pick #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/arb_lookup.sv
// Fully associative tag match plus free-slot search.
module arb_lookup #(
    parameter int ENTRIES = 8,
    parameter int AW      = 8,
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0][AW-1:0] tags,
    input  logic [ENTRIES-1:0]         used,
    input  logic [AW-1:0]              addr,
    output logic                       hit,
    output logic [IW-1:0]              hit_idx,
    output logic                       free_any,
    output logic [IW-1:0]              free_idx
);
    logic [ENTRIES-1:0] match;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match[e] = used[e] && (tags[e] == addr);
    end

    arb_pick #(.N(ENTRIES)) u_hit  (.vec(match), .any(hit),      .idx(hit_idx));
    arb_pick #(.N(ENTRIES)) u_free (.vec(~used), .any(free_any), .idx(free_idx));
endmodule

// File: rtl/arb_task_scan.sv
// Picks the forwarding source and the violated task from per-task bits.
module arb_task_scan #(
    parameter int TASKS = 4,
    localparam int TW = (TASKS > 1) ? $clog2(TASKS) : 1
) (
    input  logic [TASKS-1:0] ld_bits,
    input  logic [TASKS-1:0] st_bits,
    input  logic [TW-1:0]    task_id,
    output logic             fwd_hit,
    output logic [TW-1:0]    fwd_task,
    output logic             viol_hit,
    output logic [TW-1:0]    viol_task
);
    always_comb begin
        fwd_hit  = 1'b0;
        fwd_task = '0;
        for (int m = 0; m < TASKS; m++) begin
            if (m <= int'(task_id) && st_bits[m]) begin
                fwd_hit  = 1'b1;
                fwd_task = TW'(m);
            end
        end
    end

    always_comb begin
        logic stop;
        stop      = 1'b0;
        viol_hit  = 1'b0;
        viol_task = '0;
        for (int m = 0; m < TASKS; m++) begin
            if (!stop && m > int'(task_id)) begin
                if (ld_bits[m]) begin
                    viol_hit  = 1'b1;
                    viol_task = TW'(m);
                    stop      = 1'b1;
                end else if (st_bits[m]) begin
                    stop = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spec_arb.sv
module spec_arb #(
    parameter int ENTRIES = 8,
    parameter int TASKS   = 4,
    parameter int AW      = 8,
    parameter int DW      = 16,
    localparam int TW = (TASKS > 1) ? $clog2(TASKS) : 1,
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [TW-1:0] req_task,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          viol_valid,
    output logic [TW-1:0] viol_task,
    input  logic          commit_valid,
    input  logic [TW-1:0] commit_task,
    input  logic          squash_valid,
    input  logic [TW-1:0] squash_task,
    output logic          commit_done,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [DW-1:0] mem_rd_data,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data
);
    import arb_pkg::*;

    arb_state_e state_q, state_d;

    logic [ENTRIES-1:0][AW-1:0] tag_q;
    logic [TASKS-1:0]           ld_q  [ENTRIES];
    logic [TASKS-1:0]           st_q  [ENTRIES];
    logic [DW-1:0]              dat_q [ENTRIES][TASKS];
    logic [TW-1:0]              ctask_q;

    logic [ENTRIES-1:0] used, pend;
    logic               hit, free_any, pend_any;
    logic [IW-1:0]      hit_idx, free_idx, drain_idx, slot;
    logic [TASKS-1:0]   hit_ld, hit_st;
    logic               fwd_hit, scan_viol;
    logic [TW-1:0]      fwd_task, scan_viol_task;
    logic               accept;

    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            used[e] = (|ld_q[e]) || (|st_q[e]);
            pend[e] = st_q[e][ctask_q];
        end
    end

    arb_lookup #(.ENTRIES(ENTRIES), .AW(AW)) u_lookup (
        .tags(tag_q), .used(used), .addr(req_addr),
        .hit(hit), .hit_idx(hit_idx), .free_any(free_any), .free_idx(free_idx)
    );

    assign hit_ld = hit ? ld_q[hit_idx] : '0;
    assign hit_st = hit ? st_q[hit_idx] : '0;
    assign slot   = hit ? hit_idx : free_idx;

    arb_task_scan #(.TASKS(TASKS)) u_scan (
        .ld_bits(hit_ld), .st_bits(hit_st), .task_id(req_task),
        .fwd_hit(fwd_hit), .fwd_task(fwd_task),
        .viol_hit(scan_viol), .viol_task(scan_viol_task)
    );

    arb_pick #(.N(ENTRIES)) u_drain (.vec(pend), .any(pend_any), .idx(drain_idx));

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!squash_valid && commit_valid) state_d = ST_DRAIN;
            ST_DRAIN: if (!pend_any) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        req_ready   = 1'b0;
        mem_wr_en   = 1'b0;
        mem_wr_addr = tag_q[drain_idx];
        mem_wr_data = dat_q[drain_idx][ctask_q];
        commit_done = 1'b0;
        mem_rd_addr = req_addr;
        unique case (state_q)
            ST_IDLE:  req_ready = !squash_valid && !commit_valid && (hit || free_any);
            ST_DRAIN: begin
                mem_wr_en   = pend_any;
                commit_done = !pend_any;
            end
            default: ;
        endcase
    end

    assign accept = req_valid && req_ready;

    // Buffer contents and registered responses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q      <= '0;
            ctask_q    <= '0;
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
            viol_valid <= 1'b0;
            viol_task  <= '0;
            for (int e = 0; e < ENTRIES; e++) begin
                ld_q[e] <= '0;
                st_q[e] <= '0;
                for (int t = 0; t < TASKS; t++) dat_q[e][t] <= '0;
            end
        end else begin
            rsp_valid  <= 1'b0;
            viol_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (squash_valid) begin
                        for (int e = 0; e < ENTRIES; e++) begin
                            ld_q[e][squash_task] <= 1'b0;
                            st_q[e][squash_task] <= 1'b0;
                        end
                    end else if (commit_valid) begin
                        ctask_q <= commit_task;
                    end else if (accept) begin
                        tag_q[slot] <= req_addr;
                        if (req_write) begin
                            st_q[slot][req_task]  <= 1'b1;
                            dat_q[slot][req_task] <= req_wdata;
                            viol_valid            <= scan_viol;
                            viol_task             <= scan_viol_task;
                        end else begin
                            ld_q[slot][req_task] <= 1'b1;
                            rsp_valid            <= 1'b1;
                            rsp_data             <= fwd_hit ? dat_q[hit_idx][fwd_task]
                                                            : mem_rd_data;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (pend_any) begin
                        st_q[drain_idx][ctask_q] <= 1'b0;
                    end else begin
                        for (int e = 0; e < ENTRIES; e++) ld_q[e][ctask_q] <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/arb_props.sv
module arb_props #(
    parameter int TW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic          req_ready,
    input logic [TW-1:0] req_task,
    input logic          rsp_valid,
    input logic          viol_valid,
    input logic [TW-1:0] viol_task,
    input logic          mem_wr_en,
    input logic          commit_done,
    input logic          squash_valid
);
    // R1
    rsp_follows_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready && !req_write));

    // R4
    viol_follows_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> $past(req_valid && req_ready && req_write));

    // R4
    viol_is_younger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> (viol_task > $past(req_task)));

    // R5
    drain_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> !req_ready);

    // R5
    done_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |-> (!mem_wr_en && !req_ready));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |=> !commit_done);

    // R8
    squash_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> !req_ready);
endmodule

bind spec_arb arb_props #(.TW(TW)) u_props (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .req_task(req_task), .rsp_valid(rsp_valid),
    .viol_valid(viol_valid), .viol_task(viol_task), .mem_wr_en(mem_wr_en),
    .commit_done(commit_done), .squash_valid(squash_valid)
);

// File: tb/spec_arb_test.sv
module spec_arb_test;
    localparam int T  = 4;
    localparam int NA = 256;
    localparam int NE = 8;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [1:0] req_task = 0;
    logic [7:0] req_addr = 0;
    logic [15:0] req_wdata = 0;
    logic req_ready, rsp_valid, viol_valid, commit_done, mem_wr_en;
    logic [15:0] rsp_data, mem_rd_data, mem_wr_data;
    logic [1:0] viol_task;
    logic commit_valid = 0, squash_valid = 0;
    logic [1:0] commit_task = 0, squash_task = 0;
    logic [7:0] mem_rd_addr, mem_wr_addr;

    logic [15:0] bmem [NA];
    assign mem_rd_data = bmem[mem_rd_addr];
    always @(posedge clk) if (mem_wr_en) bmem[mem_wr_addr] <= mem_wr_data;

    spec_arb uut (.*);

    always #10 clk = ~clk;

    // Reference model
    bit          mld [NA][T];
    bit          mst [NA][T];
    logic [15:0] mdat[NA][T];
    logic [15:0] mm  [NA];
    bit          in_commit = 0;

    int checks = 0, errors = 0;

    task automatic check(bit ok, string rq, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic int used_cnt();
        int n = 0;
        for (int a = 0; a < NA; a++) begin
            bit u = 0;
            for (int t = 0; t < T; t++) u |= mld[a][t] | mst[a][t];
            if (u) n++;
        end
        return n;
    endfunction

    function automatic bit present(int a);
        for (int t = 0; t < T; t++) if (mld[a][t] || mst[a][t]) return 1;
        return 0;
    endfunction

    // R3: every clock, no write outside a commit
    always @(negedge clk) if (rst_n && !in_commit && mem_wr_en)
        check(0, "R3 write while speculative", 1, 0);

    task automatic load_op(int t, int a, string rq);
        int exp = mm[a];
        for (int m = 0; m <= t; m++) if (mst[a][m]) exp = mdat[a][m];
        @(negedge clk);
        req_valid = 1; req_write = 0; req_task = 2'(t); req_addr = 8'(a);
        #1 check(req_ready == 1, "R7 ready", req_ready, 1);
        @(negedge clk);
        req_valid = 0;
        check(rsp_valid == 1 && rsp_data == 16'(exp), rq, rsp_data, exp);
        mld[a][t] = 1;
    endtask

    task automatic store_op(int t, int a, int d);
        bit ev = 0; int et = 0;
        for (int m = t + 1; m < T; m++) begin
            if (mld[a][m]) begin ev = 1; et = m; break; end
            if (mst[a][m]) break;
        end
        @(negedge clk);
        req_valid = 1; req_write = 1; req_task = 2'(t); req_addr = 8'(a); req_wdata = 16'(d);
        #1 check(req_ready == 1, "R7 ready", req_ready, 1);
        @(negedge clk);
        req_valid = 0;
        check(viol_valid == ev, "R4 viol_valid", viol_valid, ev);
        if (ev) check(viol_task == 2'(et), "R4 viol_task", viol_task, et);
        check(rsp_valid == 0, "R4 no response to store", rsp_valid, 0);
        mst[a][t] = 1; mdat[a][t] = 16'(d);
    endtask

    task automatic squash_op(int t);
        @(negedge clk);
        squash_valid = 1; squash_task = 2'(t);
        #1 check(req_ready == 0, "R8 squash blocks", req_ready, 0);
        @(negedge clk);
        squash_valid = 0;
        for (int a = 0; a < NA; a++) begin mld[a][t] = 0; mst[a][t] = 0; end
    endtask

    task automatic commit_op(int t);
        int k = 0, n = 0, guard = 0;
        for (int a = 0; a < NA; a++) if (mst[a][t]) k++;
        @(negedge clk);
        commit_valid = 1; commit_task = 2'(t); in_commit = 1;
        @(negedge clk);
        commit_valid = 0;
        while (!commit_done && guard < 40) begin
            if (mem_wr_en) n++;
            check(req_ready == 0, "R5 busy", req_ready, 0);
            @(negedge clk);
            guard++;
        end
        check(commit_done == 1 && mem_wr_en == 0, "R5 done pulse", commit_done, 1);
        check(n == k, "R5 write count", n, k);
        @(negedge clk);
        in_commit = 0;
        check(commit_done == 0, "R5 done one cycle", commit_done, 0);
        for (int a = 0; a < NA; a++) begin
            if (mst[a][t]) mm[a] = mdat[a][t];
            mld[a][t] = 0; mst[a][t] = 0;
        end
        begin
            int bad = 0;
            for (int a = 0; a < NA; a++) if (bmem[a] !== mm[a]) bad++;
            check(bad == 0, "R5 memory contents", bad, 0);
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < NA; a++) begin
            bmem[a] = 16'(a * 3 + 1); mm[a] = 16'(a * 3 + 1);
            for (int t = 0; t < T; t++) begin mld[a][t] = 0; mst[a][t] = 0; mdat[a][t] = 0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R8 reset state
        check(req_ready == 1, "R8 reset ready", req_ready, 1);
        check(rsp_valid == 0 && viol_valid == 0, "R8 reset outputs", rsp_valid, 0);
        check(mem_wr_en == 0 && commit_done == 0, "R8 reset idle", mem_wr_en, 0);

        load_op(2, 10, "R1 miss from memory");
        store_op(0, 10, 16'hAAAA);            // R4 violates task 2
        squash_op(2);                         // R6
        load_op(2, 10, "R2 forward from task 0");
        store_op(1, 10, 16'hBBBB);            // R4 violates task 2 again
        store_op(0, 10, 16'hCCCC);            // R4 shielded by task 1 store
        load_op(3, 10, "R2 nearest older is task 1");
        load_op(0, 10, "R2 own task store");
        check(bmem[10] == mm[10], "R3 memory untouched", bmem[10], mm[10]);

        commit_op(0);                         // R5

        // R7 fill the buffer
        for (int a = 40; used_cnt() < NE; a++) load_op(3, a, "R1 fill");
        @(negedge clk);
        req_valid = 1; req_write = 0; req_task = 3; req_addr = 60;
        #1 check(req_ready == 0, "R7 full stall", req_ready, 0);
        @(negedge clk);
        #1 check(req_ready == 0, "R7 still stalled", req_ready, 0);
        req_valid = 0;
        @(negedge clk);
        check(rsp_valid == 0, "R7 no response", rsp_valid, 0);
        load_op(2, 41, "R7 hit while full");

        squash_op(3);                         // R6 frees entries
        check(!present(60) && used_cnt() < NE, "R6 model free", used_cnt(), NE - 1);
        load_op(3, 60, "R6 reuse freed entry");

        // R8 simultaneous squash, commit, request
        @(negedge clk);
        squash_valid = 1; squash_task = 3; commit_valid = 1; commit_task = 1;
        req_valid = 1; req_write = 0; req_task = 1; req_addr = 10;
        #1 check(req_ready == 0, "R8 squash wins", req_ready, 0);
        @(negedge clk);
        squash_valid = 0; commit_valid = 0; req_valid = 0;
        for (int a = 0; a < NA; a++) begin mld[a][3] = 0; mst[a][3] = 0; end
        check(rsp_valid == 0, "R8 request dropped", rsp_valid, 0);
        repeat (3) begin
            @(negedge clk);
            check(commit_done == 0, "R8 commit dropped", commit_done, 0);
        end

        commit_op(1);
        commit_op(2);
        commit_op(3);
        check(bmem[10] == 16'hBBBB, "R5 final value", bmem[10], 16'hBBBB);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule